// File: doc/BRIEF.md
# Three-Channel Trimmed Gain Clipper

This block sits right after digitisation in a three-component video path. Each sample clock it takes one 10-bit unsigned sample per channel, scales every channel by its own fine gain near unity, rounds the result and saturates it to the legal 10-bit code range. An input that is too hot, or a gain set too high, therefore clips at full scale and never wraps to a small code.

Each channel's gain is a signed trim code written by the embedded processor through a simple write port. The port accepts a channel index and a code. Codes beyond the allowed trim are clamped when they are written. The gain value is captured together with each sample, so a single output sample is always computed with one gain only. The sample-valid flag and the sync sideband bits travel through a delay line of the same length as the arithmetic pipeline. This keeps them aligned with the data.

Top module: `trim_gain_clip3`

## Requirements
- R1: While reset (rst_n low) is applied, and afterwards until new samples come out, out_valid, out_sync and out_data are all zero. Every channel's trim code resets to 0, which is unity gain.
- R2: With trim code 0, every channel outputs its input sample unchanged, exactly 3 clock edges after the sample was captured.
- R3: With two's-complement trim code g, channel output = min(1023, floor((x*(2048+g) + 1024) / 2048)), where x is the input sample. One code step is a gain step of 1/2048.
- R4: A write stores the code clamped to the range -307..+307 (about ±15%). For example, +511 or +308 is stored as +307, and -512 is stored as -307.
- R5: Results above 1023 saturate at 1023 and never wrap. The output stays within 0..1023.
- R6: wr_ch values 0, 1 and 2 select the channel whose data sits in in_data bits [10c+9:10c]. Channel gains are independent of each other. A write with wr_ch = 3 changes no gain.
- R7: A write captured at clock edge t applies to samples captured at edge t+1 and later. A sample captured at edge t, or earlier, uses the previous gain.
- R8: out_valid and out_sync equal in_valid and in_sync as captured 3 clock edges earlier.
- R9: out_data is all zero whenever out_valid is low.
- R10: Rounding is half-up. For example, x=512 gives 513 with g=+2 and 512 with g=-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input samples valid this clock |
| in_sync | input | 2 | Sync sideband bits, delayed along with the samples |
| in_data | input | 30 | Three 10-bit samples; channel c in bits [10c+9:10c] |
| wr_en | input | 1 | Gain write strobe |
| wr_ch | input | 2 | Channel index of the write (3 is ignored) |
| wr_gain | input | 10 | Two's-complement trim code to write |
| out_valid | output | 1 | Output samples valid |
| out_sync | output | 2 | Delayed sync sideband |
| out_data | output | 30 | Three scaled, rounded and clipped samples |

## Verification
A full ramp over all 1024 input codes at unity shows the 3-cycle latency and an exact pass-through. Repeating the ramp at six trim codes, with a different code on each channel, separates a correct product from sign-extension or channel-swap faults. The same ramps also reach the saturation point from both sides. Out-of-range writes at moderate amplitudes show the clamp without clipping hiding it, and exact half-step products show the rounding direction. A write in the middle of a stream, with the write cycle tagged, shows which sample first takes the new gain. Random valid and sync gaps show the sideband alignment and the zeroed idle output.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
    // Fixed depth of the data pipeline and of the sideband delay line
    localparam int unsigned TGC_PIPE_DEPTH = 3;

    // Index width for a selector over n items, at least one bit
    function automatic int unsigned sel_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/tgc_gain_regs.sv
module tgc_gain_regs #(
    parameter int unsigned NUM_CH   = 3,
    parameter int unsigned GAIN_W   = 10,
    parameter int unsigned GAIN_LIM = 307,
    parameter int unsigned CH_W     = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [CH_W-1:0]                wr_ch,
    input  logic [GAIN_W-1:0]              wr_gain,
    output logic [NUM_CH-1:0][GAIN_W-1:0]  gain_q
);
    localparam logic signed [GAIN_W-1:0] LIM_P = GAIN_W'(GAIN_LIM);
    localparam logic signed [GAIN_W-1:0] LIM_N = -LIM_P;

    logic signed [GAIN_W-1:0] wr_sat;

    // Clamp the incoming code once, at write time
    always_comb begin
        if ($signed(wr_gain) > LIM_P) begin
            wr_sat = LIM_P;
        end else if ($signed(wr_gain) < LIM_N) begin
            wr_sat = LIM_N;
        end else begin
            wr_sat = $signed(wr_gain);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < int'(NUM_CH); i++) begin
                if (wr_ch == CH_W'(i)) begin
                    gain_q[i] <= wr_sat;
                end
            end
        end
    end
endmodule

// File: rtl/tgc_sb_delay.sv
module tgc_sb_delay #(
    parameter int unsigned W     = 3,
    parameter int unsigned DEPTH = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [W-1:0]             d,
    output logic [DEPTH-1:0][W-1:0]  taps
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taps <= '0;
        end else begin
            taps[0] <= d;
            for (int i = 1; i < int'(DEPTH); i++) begin
                taps[i] <= taps[i-1];
            end
        end
    end
endmodule

// File: rtl/tgc_lane.sv
module tgc_lane #(
    parameter int unsigned DATA_W = 10,
    parameter int unsigned GAIN_W = 10,
    parameter int unsigned FRAC_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_s0,   // sample presented this clock
    input  logic               live_s1,   // stage-1 holds a valid sample
    input  logic               live_s2,   // stage-2 holds a valid sample
    input  logic [DATA_W-1:0]  x,
    input  logic [GAIN_W-1:0]  gain,
    output logic [DATA_W-1:0]  y
);
    localparam int unsigned FAC_W  = FRAC_W + 1;
    localparam int unsigned PROD_W = DATA_W + FAC_W;
    localparam int unsigned SUM_W  = PROD_W + 1;
    localparam int unsigned Q_W    = SUM_W - FRAC_W;
    localparam logic [FAC_W-1:0] UNITY = {1'b1, {FRAC_W{1'b0}}};
    localparam logic [SUM_W-1:0] HALF  = SUM_W'(1) << (FRAC_W - 1);
    localparam logic [Q_W-1:0]   TOP   = Q_W'((1 << DATA_W) - 1);

    logic [FAC_W-1:0]  fac_c;
    logic [DATA_W-1:0] x_s1;
    logic [FAC_W-1:0]  fac_s1;
    logic [PROD_W-1:0] prod_s2;
    logic [SUM_W-1:0]  sum_c;
    logic [Q_W-1:0]    q_c;

    // Unity plus sign-extended trim: always positive for legal codes
    assign fac_c = UNITY + {{(FAC_W-GAIN_W){gain[GAIN_W-1]}}, gain};

    // Stage 1: capture sample and the gain it will use
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_s1   <= '0;
            fac_s1 <= UNITY;
        end else if (take_s0) begin
            x_s1   <= x;
            fac_s1 <= fac_c;
        end
    end

    // Stage 2: full product
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_s2 <= '0;
        end else if (live_s1) begin
            prod_s2 <= PROD_W'(x_s1) * PROD_W'(fac_s1);
        end
    end

    // Stage 3: round half-up, then saturate
    assign sum_c = {1'b0, prod_s2} + HALF;
    assign q_c   = Q_W'(sum_c >> FRAC_W);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y <= '0;
        end else if (!live_s2) begin
            y <= '0;
        end else if (q_c > TOP) begin
            y <= '1;
        end else begin
            y <= q_c[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/trim_gain_clip3.sv
module trim_gain_clip3
    import tgc_pkg::*;
#(
    parameter int unsigned NUM_CH   = 3,
    parameter int unsigned DATA_W   = 10,
    parameter int unsigned GAIN_W   = 10,
    parameter int unsigned FRAC_W   = 11,
    parameter int unsigned GAIN_LIM = 307,
    parameter int unsigned SYNC_W   = 2,
    localparam int unsigned CH_W    = sel_width(NUM_CH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [SYNC_W-1:0]         in_sync,
    input  logic [NUM_CH*DATA_W-1:0]  in_data,
    input  logic                      wr_en,
    input  logic [CH_W-1:0]           wr_ch,
    input  logic [GAIN_W-1:0]         wr_gain,
    output logic                      out_valid,
    output logic [SYNC_W-1:0]         out_sync,
    output logic [NUM_CH*DATA_W-1:0]  out_data
);
    localparam int unsigned SB_W  = SYNC_W + 1;
    localparam int unsigned DEPTH = TGC_PIPE_DEPTH;

    logic [NUM_CH-1:0][GAIN_W-1:0] gain_q;
    logic [DEPTH-1:0][SB_W-1:0]    sb_taps;

    tgc_gain_regs #(
        .NUM_CH   (NUM_CH),
        .GAIN_W   (GAIN_W),
        .GAIN_LIM (GAIN_LIM),
        .CH_W     (CH_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_gain (wr_gain),
        .gain_q  (gain_q)
    );

    tgc_sb_delay #(
        .W     (SB_W),
        .DEPTH (DEPTH)
    ) u_sb (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({in_sync, in_valid}),
        .taps  (sb_taps)
    );

    for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_lane
        tgc_lane #(
            .DATA_W (DATA_W),
            .GAIN_W (GAIN_W),
            .FRAC_W (FRAC_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .take_s0 (in_valid),
            .live_s1 (sb_taps[0][0]),
            .live_s2 (sb_taps[1][0]),
            .x       (in_data[c*DATA_W +: DATA_W]),
            .gain    (gain_q[c]),
            .y       (out_data[c*DATA_W +: DATA_W])
        );
    end

    assign out_valid = sb_taps[DEPTH-1][0];
    assign out_sync  = sb_taps[DEPTH-1][SB_W-1:1];
endmodule

// File: rtl/tgc_checker.sv
module tgc_checker #(
    parameter int unsigned NUM_CH   = 3,
    parameter int unsigned DATA_W   = 10,
    parameter int unsigned GAIN_W   = 10,
    parameter int unsigned GAIN_LIM = 307,
    parameter int unsigned SYNC_W   = 2,
    parameter int unsigned CH_W     = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           in_valid,
    input logic [SYNC_W-1:0]              in_sync,
    input logic [NUM_CH*DATA_W-1:0]       in_data,
    input logic                           wr_en,
    input logic [CH_W-1:0]                wr_ch,
    input logic                           out_valid,
    input logic [SYNC_W-1:0]              out_sync,
    input logic [NUM_CH*DATA_W-1:0]       out_data,
    input logic [NUM_CH-1:0][GAIN_W-1:0]  gain_q
);
    localparam logic signed [GAIN_W-1:0] LIM_P = GAIN_W'(GAIN_LIM);

    // Counts edges since reset so that history looks are only used once filled
    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= 2'd0;
        end else if (warm != 2'd3) begin
            warm <= warm + 2'd1;
        end
    end

    p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    p_sync_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (out_sync == $past(in_sync, 3)));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && !$past(in_valid, 3)) |-> (out_data == '0));

    p_bad_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ch >= CH_W'(NUM_CH)) |=> $stable(gain_q));

    for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_chk
        p_gain_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($signed(gain_q[c]) <= LIM_P) && ($signed(gain_q[c]) >= -LIM_P));

        p_unity_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (warm == 2'd3 && $past(in_valid, 3) && $past(gain_q[c], 3) == '0)
            |-> (out_data[c*DATA_W +: DATA_W] == $past(in_data[c*DATA_W +: DATA_W], 3)));
    end
endmodule

bind trim_gain_clip3 tgc_checker #(
    .NUM_CH   (NUM_CH),
    .DATA_W   (DATA_W),
    .GAIN_W   (GAIN_W),
    .GAIN_LIM (GAIN_LIM),
    .SYNC_W   (SYNC_W),
    .CH_W     (CH_W)
) u_tgc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sync   (in_sync),
    .in_data   (in_data),
    .wr_en     (wr_en),
    .wr_ch     (wr_ch),
    .out_valid (out_valid),
    .out_sync  (out_sync),
    .out_data  (out_data),
    .gain_q    (gain_q)
);

// File: tb/tb_trim_gain_clip3.sv
module tb_trim_gain_clip3;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  in_sync;
    logic [29:0] in_data;
    logic        wr_en;
    logic [1:0]  wr_ch;
    logic [9:0]  wr_gain;
    logic        out_valid;
    logic [1:0]  out_sync;
    logic [29:0] out_data;

    always #4 clk = ~clk;

    trim_gain_clip3 dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
        .in_data(in_data), .wr_en(wr_en), .wr_ch(wr_ch), .wr_gain(wr_gain),
        .out_valid(out_valid), .out_sync(out_sync), .out_data(out_data)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Expected history: index 0 newest, index 2 due at the current negedge
    logic  h_v[3];
    int    h_s[3];
    int    h_d[3][3];
    string h_tag[3][3];
    int    g_model[3];

    function automatic int clamp_code(input int g);
        if (g > 307)  return 307;
        if (g < -307) return -307;
        return g;
    endfunction

    function automatic int raw_val(input int x, input int g);
        return (x * (2048 + g) + 1024) / 2048;
    endfunction

    function automatic int clip_val(input int v);
        return (v > 1023) ? 1023 : v;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input int s, input int x0, input int x1, input int x2,
                        input logic we, input int wch, input int wg, input string tag);
        int xs[3];
        @(negedge clk);
        chk("R8", "out_valid", int'(out_valid), int'(h_v[2]));
        chk("R8", "out_sync", int'(out_sync), h_s[2]);
        for (int c = 0; c < 3; c++) begin
            if (h_v[2]) chk(h_tag[2][c], $sformatf("ch%0d", c), int'(out_data[c*10 +: 10]), h_d[2][c]);
            else        chk("R9", $sformatf("idle ch%0d", c), int'(out_data[c*10 +: 10]), 0);
        end
        for (int k = 2; k > 0; k--) begin
            h_v[k] = h_v[k-1];
            h_s[k] = h_s[k-1];
            for (int c = 0; c < 3; c++) begin
                h_d[k][c]   = h_d[k-1][c];
                h_tag[k][c] = h_tag[k-1][c];
            end
        end
        xs[0] = x0; xs[1] = x1; xs[2] = x2;
        in_valid = v;
        in_sync  = s[1:0];
        in_data  = {xs[2][9:0], xs[1][9:0], xs[0][9:0]};
        wr_en    = we;
        wr_ch    = wch[1:0];
        wr_gain  = wg[9:0];
        h_v[0] = v;
        h_s[0] = s;
        for (int c = 0; c < 3; c++) begin
            h_d[0][c]   = clip_val(raw_val(xs[c], g_model[c]));
            h_tag[0][c] = (raw_val(xs[c], g_model[c]) > 1023) ? "R5" : tag;
        end
        if (we && wch < 3) g_model[wch] = clamp_code(wg);
    endtask

    task automatic wr(input int ch, input int g, input string tag);
        step(1'b0, 0, 0, 0, 0, 1'b1, ch, g, tag);
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    int gl[6];

    initial begin
        for (int k = 0; k < 3; k++) begin
            h_v[k] = 1'b0;
            h_s[k] = 0;
            for (int c = 0; c < 3; c++) begin
                h_d[k][c]   = 0;
                h_tag[k][c] = "R1";
            end
            g_model[k] = 0;
        end
        rst_n = 1'b0; in_valid = 1'b1; in_sync = 2'b11; in_data = '1;
        wr_en = 1'b0; wr_ch = 2'd0; wr_gain = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state with active-looking inputs
        chk("R1", "reset out_valid", int'(out_valid), 0);
        chk("R1", "reset out_sync", int'(out_sync), 0);
        chk("R1", "reset out_data", int'(out_data != '0), 0);
        in_valid = 1'b0; in_sync = 2'b00; in_data = '0;
        rst_n = 1'b1;

        // R1/R2: unity gain after reset, full ramp on every channel
        for (int x = 0; x < 1024; x++)
            step(1'b1, x % 4, x, 1023 - x, (x * 37) % 1024, 1'b0, 0, 0, (x < 4) ? "R1" : "R2");

        // R3/R5/R6: six trim codes, different on each channel
        gl[0] = -307; gl[1] = -200; gl[2] = -1; gl[3] = 1; gl[4] = 100; gl[5] = 307;
        for (int k = 0; k < 6; k++) begin
            wr(0, gl[k], "R6");
            wr(1, -gl[k], "R6");
            wr(2, gl[(k + 1) % 6], "R6");
            for (int x = 0; x < 1024; x++)
                step(1'b1, 0, x, 1023 - x, (x * 37) % 1024, 1'b0, 0, 0, "R3");
        end

        // R10: half-step rounding
        wr(0, 2, "R10"); wr(1, -2, "R10"); wr(2, 0, "R10");
        step(1'b1, 1, 512, 512, 512, 1'b0, 0, 0, "R10");
        step(1'b1, 2, 256, 768, 1, 1'b0, 0, 0, "R10");

        // R4: out-of-range codes clamped at write time
        wr(0, 511, "R4"); wr(1, -512, "R4"); wr(2, 308, "R4");
        for (int x = 0; x <= 800; x += 4)
            step(1'b1, 0, x, x, x, 1'b0, 0, 0, "R4");

        // R6: write to index 3 changes nothing
        step(1'b1, 0, 700, 700, 700, 1'b1, 3, -100, "R6");
        for (int x = 0; x < 8; x++)
            step(1'b1, 0, 600 + x, 500 + x, 400 + x, 1'b0, 0, 0, "R6");

        // R7: gain change mid-stream, sample on write cycle uses old gain
        wr(0, 0, "R7"); wr(1, 0, "R7"); wr(2, 0, "R7");
        step(1'b1, 0, 800, 800, 800, 1'b0, 0, 0, "R7");
        step(1'b1, 0, 800, 800, 800, 1'b1, 0, 200, "R7");
        step(1'b1, 0, 800, 800, 800, 1'b1, 2, -150, "R7");
        step(1'b1, 0, 800, 800, 800, 1'b0, 0, 0, "R7");
        step(1'b1, 0, 800, 800, 800, 1'b0, 0, 0, "R7");

        // R8/R9: random valid gaps and sync, random data
        for (int i = 0; i < 600; i++)
            step(1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 1023)), int'($urandom_range(0, 1023)),
                 int'($urandom_range(0, 1023)), 1'b0, 0, 0, "R8");

        // drain
        repeat (4) step(1'b0, 0, 0, 0, 0, 1'b0, 0, 0, "R9");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule